// File: doc/BRIEF.md
# Radio SPI Transaction Engine

This block is an SPI master that runs the four command-level transactions of a packet radio transceiver: register write, register read, frame-buffer write and frame-buffer read. A requester presents one command, made of an opcode, a 6-bit register address, a data byte and a buffer length, while the engine is not busy. The engine then frames the whole transaction under one active-low chip-select and shifts every byte in SPI mode 0, most significant bit first.

Frame payload moves over byte streams with valid/ready handshakes. Bytes to send come in on a transmit stream. Bytes that are read out leave on a receive stream, which the requester may stall. For a frame read, the transceiver's first returned byte gives the frame length. The engine adds one to that length for the trailing link-quality byte and limits the result to the caller's buffer size. It then reports how many bytes it delivered. The transceiver's interrupt pin passes through a synchroniser and appears as an active-high level.

Top module: `rspi_engine`

## Requirements
- R1: In reset and immediately after it, `spi_cs_n` is 1, `spi_sck` is 0, and `busy`, `done` and `irq_flag` are 0.
- R2: Every byte on `spi_mosi` goes out most significant bit first. `spi_sck` idles low, and each bit is one high pulse. `spi_mosi` is stable while `spi_sck` is high, and the slave samples it on the rising edge.
- R3: Register write (`cmd_op`=0) sends 0xC0 OR `cmd_addr`, then `cmd_data`. That is exactly two bytes under one select.
- R4: Register read (`cmd_op`=1) sends 0x80 OR `cmd_addr`, then one 0x00 byte. The byte received during that second slot appears on `rd_data`, with a one-cycle `rd_valid` pulse.
- R5: Buffer write (`cmd_op`=2) sends 0x60, then `cmd_len`, then exactly `cmd_len` payload bytes taken in order from the transmit stream. A length of 0 sends only the first two bytes.
- R6: Buffer read (`cmd_op`=3) sends 0x20 and then 0x00 filler bytes. The first received byte L sets the count to min(L+1, `cmd_len`). That many further bytes are received and offered in order on the receive stream. Each byte is held stable until `rx_ready` is seen.
- R7: At the end of a transaction `done` pulses for one cycle. `done_count` then holds the number of bytes delivered by a buffer read, and 0 for the other opcodes.
- R8: `busy` is high from the cycle a command is accepted until the cycle `spi_cs_n` returns high. A `cmd_valid` seen while busy is ignored and starts no transaction.
- R9: `irq_flag` equals the level of `irq_in` delayed by the synchroniser depth (2 clock cycles by default).
- R10: `spi_sck` is low whenever `spi_cs_n` is high. Between two transactions `spi_cs_n` stays high for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present; accepted when `busy` is low |
| cmd_op | input | 2 | 0 reg write, 1 reg read, 2 buffer write, 3 buffer read |
| cmd_addr | input | 6 | Register address |
| cmd_data | input | 8 | Register write data |
| cmd_len | input | 8 | Buffer write length, or maximum buffer read length |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| done_count | output | 8 | Bytes delivered by the last buffer read |
| rd_valid | output | 1 | Register read result pulse |
| rd_data | output | 8 | Register read result |
| tx_valid | input | 1 | Payload byte offered |
| tx_data | input | 8 | Payload byte |
| tx_ready | output | 1 | Engine takes the payload byte |
| rx_valid | output | 1 | Received frame byte offered |
| rx_data | output | 8 | Received frame byte |
| rx_ready | input | 1 | Requester takes the frame byte |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the transceiver |
| spi_miso | input | 1 | Serial data from the transceiver |
| irq_in | input | 1 | Raw interrupt pin |
| irq_flag | output | 1 | Synchronised interrupt level |

## Verification
Each serial byte takes 16×HALF_DIV system cycles plus about two cycles of restart, so the bench never counts serial timing. The SPI slave model is driven by the edges of `spi_sck` and `spi_cs_n` and compares every byte with the expected queue as the byte completes. The result outputs are sampled on the falling clock edge: `rd_valid` and `done` are single-cycle pulses, and `done` appears in the same cycle that `spi_cs_n` rises. A receive byte counts as delivered only when `rx_valid` and the `rx_ready` value the bench has just set are both high. The interrupt flag is checked one cycle after the pin changes, when it must still be old, and two cycles after, when it must be new.

// File: rtl/rspi_pkg.sv
package rspi_pkg;

    typedef enum logic [1:0] {
        OP_REG_WR = 2'd0,
        OP_REG_RD = 2'd1,
        OP_BUF_WR = 2'd2,
        OP_BUF_RD = 2'd3
    } op_e;

    localparam logic [7:0] PFX_REG_WR = 8'hC0;
    localparam logic [7:0] PFX_REG_RD = 8'h80;
    localparam logic [7:0] PFX_BUF_WR = 8'h60;
    localparam logic [7:0] PFX_BUF_RD = 8'h20;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD,
        S_TAIL,
        S_RD,
        S_BW_SHIFT,
        S_BW_WAIT,
        S_BR_LEN,
        S_BR_SHIFT,
        S_BR_OUT
    } eng_state_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_HIGH
    } phase_e;

endpackage

// File: rtl/rspi_byte_shifter.sv
module rspi_byte_shifter
    import rspi_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    output logic [7:0] rx_byte,
    output logic       done,
    output logic       sck,
    output logic       mosi,
    input  logic       miso
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] CNT_RELOAD = CW'(HALF_DIV - 1);

    typedef struct packed {
        phase_e      phase;
        logic [CW-1:0] cnt;
        logic [2:0]  bitn;
        logic [7:0]  tx;
        logic [7:0]  rx;
        logic        sck;
        logic        done;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d      = sh_q;
        sh_d.done = 1'b0;
        case (sh_q.phase)
            PH_IDLE: begin
                if (start) begin
                    sh_d.tx    = tx_byte;
                    sh_d.bitn  = 3'd0;
                    sh_d.cnt   = CNT_RELOAD;
                    sh_d.phase = PH_LOW;
                end
            end
            PH_LOW: begin
                if (sh_q.cnt == '0) begin
                    sh_d.rx    = {sh_q.rx[6:0], miso};
                    sh_d.sck   = 1'b1;
                    sh_d.cnt   = CNT_RELOAD;
                    sh_d.phase = PH_HIGH;
                end else begin
                    sh_d.cnt = sh_q.cnt - 1'b1;
                end
            end
            PH_HIGH: begin
                if (sh_q.cnt == '0) begin
                    sh_d.sck = 1'b0;
                    if (sh_q.bitn == 3'd7) begin
                        sh_d.phase = PH_IDLE;
                        sh_d.done  = 1'b1;
                    end else begin
                        sh_d.bitn  = sh_q.bitn + 3'd1;
                        sh_d.tx    = {sh_q.tx[6:0], 1'b0};
                        sh_d.cnt   = CNT_RELOAD;
                        sh_d.phase = PH_LOW;
                    end
                end else begin
                    sh_d.cnt = sh_q.cnt - 1'b1;
                end
            end
            default: sh_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            sh_q <= sh_d;
        end
    end

    assign rx_byte = sh_q.rx;
    assign done    = sh_q.done;
    assign sck     = sh_q.sck;
    assign mosi    = sh_q.tx[7];

endmodule

// File: rtl/rspi_sync.sv
module rspi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = async_in;
        for (int k = 1; k < STAGES; k++) begin
            st_d[k] = st_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_out = st_q[STAGES-1];

endmodule

// File: rtl/rspi_engine.sv
module rspi_engine
    import rspi_pkg::*;
#(
    parameter int HALF_DIV    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic [5:0] cmd_addr,
    input  logic [7:0] cmd_data,
    input  logic [7:0] cmd_len,
    output logic       busy,
    output logic       done,
    output logic [7:0] done_count,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    output logic       tx_ready,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    input  logic       rx_ready,
    output logic       spi_cs_n,
    output logic       spi_sck,
    output logic       spi_mosi,
    input  logic       spi_miso,
    input  logic       irq_in,
    output logic       irq_flag
);
    typedef struct packed {
        eng_state_e state;
        op_e        op;
        logic [7:0] data;
        logic [7:0] len;
        logic [7:0] remain;
        logic [7:0] count;
        logic       cs_n;
        logic       start;
        logic [7:0] byte_out;
        logic       rd_valid;
        logic [7:0] rd_data;
        logic       rx_valid;
        logic [7:0] rx_data;
        logic       done;
        logic [7:0] done_count;
    } eng_t;

    eng_t       eng_d, eng_q;
    logic       sh_done;
    logic [7:0] sh_rx;
    logic       fin;
    logic [8:0] want_len;

    rspi_byte_shifter #(.HALF_DIV(HALF_DIV)) shifter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (eng_q.start),
        .tx_byte (eng_q.byte_out),
        .rx_byte (sh_rx),
        .done    (sh_done),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .miso    (spi_miso)
    );

    rspi_sync #(.STAGES(SYNC_STAGES)) irq_sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_in),
        .sync_out (irq_flag)
    );

    assign want_len = {1'b0, sh_rx} + 9'd1;

    always_comb begin
        eng_d          = eng_q;
        eng_d.start    = 1'b0;
        eng_d.rd_valid = 1'b0;
        eng_d.done     = 1'b0;
        fin            = 1'b0;
        case (eng_q.state)
            S_IDLE: begin
                if (cmd_valid) begin
                    eng_d.op    = op_e'(cmd_op);
                    eng_d.data  = cmd_data;
                    eng_d.len   = cmd_len;
                    eng_d.count = 8'd0;
                    eng_d.cs_n  = 1'b0;
                    eng_d.start = 1'b1;
                    eng_d.state = S_CMD;
                    case (op_e'(cmd_op))
                        OP_REG_WR: eng_d.byte_out = PFX_REG_WR | {2'b00, cmd_addr};
                        OP_REG_RD: eng_d.byte_out = PFX_REG_RD | {2'b00, cmd_addr};
                        OP_BUF_WR: eng_d.byte_out = PFX_BUF_WR;
                        default:   eng_d.byte_out = PFX_BUF_RD;
                    endcase
                end
            end
            S_CMD: begin
                if (sh_done) begin
                    eng_d.start = 1'b1;
                    case (eng_q.op)
                        OP_REG_WR: begin
                            eng_d.byte_out = eng_q.data;
                            eng_d.state    = S_TAIL;
                        end
                        OP_REG_RD: begin
                            eng_d.byte_out = 8'h00;
                            eng_d.state    = S_RD;
                        end
                        OP_BUF_WR: begin
                            eng_d.byte_out = eng_q.len;
                            eng_d.remain   = eng_q.len;
                            eng_d.state    = S_BW_SHIFT;
                        end
                        default: begin
                            eng_d.byte_out = 8'h00;
                            eng_d.state    = S_BR_LEN;
                        end
                    endcase
                end
            end
            S_TAIL: begin
                if (sh_done) fin = 1'b1;
            end
            S_RD: begin
                if (sh_done) begin
                    eng_d.rd_data  = sh_rx;
                    eng_d.rd_valid = 1'b1;
                    fin            = 1'b1;
                end
            end
            S_BW_SHIFT: begin
                if (sh_done) begin
                    if (eng_q.remain == 8'd0) fin = 1'b1;
                    else eng_d.state = S_BW_WAIT;
                end
            end
            S_BW_WAIT: begin
                if (tx_valid) begin
                    eng_d.start    = 1'b1;
                    eng_d.byte_out = tx_data;
                    eng_d.remain   = eng_q.remain - 8'd1;
                    eng_d.state    = S_BW_SHIFT;
                end
            end
            S_BR_LEN: begin
                if (sh_done) begin
                    eng_d.remain = (want_len > {1'b0, eng_q.len}) ? eng_q.len : want_len[7:0];
                    if (eng_d.remain == 8'd0) begin
                        fin = 1'b1;
                    end else begin
                        eng_d.start    = 1'b1;
                        eng_d.byte_out = 8'h00;
                        eng_d.state    = S_BR_SHIFT;
                    end
                end
            end
            S_BR_SHIFT: begin
                if (sh_done) begin
                    eng_d.rx_data  = sh_rx;
                    eng_d.rx_valid = 1'b1;
                    eng_d.remain   = eng_q.remain - 8'd1;
                    eng_d.count    = eng_q.count + 8'd1;
                    eng_d.state    = S_BR_OUT;
                end
            end
            S_BR_OUT: begin
                if (rx_ready) begin
                    eng_d.rx_valid = 1'b0;
                    if (eng_q.remain == 8'd0) begin
                        fin = 1'b1;
                    end else begin
                        eng_d.start    = 1'b1;
                        eng_d.byte_out = 8'h00;
                        eng_d.state    = S_BR_SHIFT;
                    end
                end
            end
            default: eng_d.state = S_IDLE;
        endcase
        if (fin) begin
            eng_d.cs_n       = 1'b1;
            eng_d.done       = 1'b1;
            eng_d.done_count = (eng_q.op == OP_BUF_RD) ? eng_d.count : 8'd0;
            eng_d.state      = S_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{state: S_IDLE, op: OP_REG_WR, cs_n: 1'b1, default: '0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign busy       = (eng_q.state != S_IDLE);
    assign done       = eng_q.done;
    assign done_count = eng_q.done_count;
    assign rd_valid   = eng_q.rd_valid;
    assign rd_data    = eng_q.rd_data;
    assign tx_ready   = (eng_q.state == S_BW_WAIT);
    assign rx_valid   = eng_q.rx_valid;
    assign rx_data    = eng_q.rx_data;
    assign spi_cs_n   = eng_q.cs_n;

endmodule

// File: rtl/rspi_engine_chk.sv
module rspi_engine_chk #(
    parameter int SYNC_STAGES = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       rd_valid,
    input logic       rx_valid,
    input logic       rx_ready,
    input logic [7:0] rx_data,
    input logic       spi_cs_n,
    input logic       spi_sck,
    input logic       spi_mosi,
    input logic       irq_in,
    input logic       irq_flag
);
    logic [SYNC_STAGES-1:0] irq_hist;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_hist <= '0;
        end else begin
            for (int k = SYNC_STAGES - 1; k > 0; k--) begin
                irq_hist[k] <= irq_hist[k-1];
            end
            irq_hist[0] <= irq_in;
        end
    end

    a_r10_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    a_r8_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_cs_n);

    a_r8_select_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> busy);

    a_r2_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

    a_r4_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    a_r9_irq_delay: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag == irq_hist[SYNC_STAGES-1]);

endmodule

bind rspi_engine rspi_engine_chk #(.SYNC_STAGES(SYNC_STAGES)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .rd_valid (rd_valid),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_data  (rx_data),
    .spi_cs_n (spi_cs_n),
    .spi_sck  (spi_sck),
    .spi_mosi (spi_mosi),
    .irq_in   (irq_in),
    .irq_flag (irq_flag)
);

// File: tb/rspi_engine_tb_top.sv
module rspi_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [5:0] cmd_addr = '0;
    logic [7:0] cmd_data = '0;
    logic [7:0] cmd_len = '0;
    logic       busy, done, rd_valid, tx_ready, rx_valid;
    logic [7:0] done_count, rd_data, rx_data;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = '0;
    logic       rx_ready = 1'b0;
    logic       spi_cs_n, spi_sck, spi_mosi;
    logic       spi_miso = 1'b0;
    logic       irq_in = 1'b0;
    logic       irq_flag;

    rspi_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_len(cmd_len),
        .busy(busy), .done(done), .done_count(done_count),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .irq_in(irq_in), .irq_flag(irq_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int n_done = 0;
    int bp = 0;

    typedef struct {
        int    kind;
        int    val;
        string req;
    } item_t;

    item_t    exp_q[$];
    logic [7:0] mosi_exp[$];
    string    mosi_req[$];
    logic [7:0] resp_q[$];
    logic [7:0] tx_src[$];

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, expv, $time);
        end
    endtask

    // SPI slave model: samples on rising sck, shifts out on falling sck
    logic [7:0] s_cur = '0;
    logic [7:0] s_in = '0;
    int         s_bits = 0;

    always @(negedge spi_cs_n) begin
        s_bits   = 0;
        s_cur    = (resp_q.size() > 0) ? resp_q.pop_front() : 8'h00;
        spi_miso = s_cur[7];
    end

    always @(posedge spi_sck) begin
        check(!spi_cs_n, "R10", spi_cs_n, 0);
        s_in   = {s_in[6:0], spi_mosi};
        s_cur  = {s_cur[6:0], 1'b0};
        s_bits = s_bits + 1;
        if (s_bits == 8) begin
            s_bits = 0;
            if (mosi_exp.size() == 0) begin
                check(1'b0, "R8", s_in, -1);
            end else begin
                automatic logic [7:0] e = mosi_exp.pop_front();
                automatic string r = mosi_req.pop_front();
                check(s_in == e, r, s_in, e);
            end
            s_cur = (resp_q.size() > 0) ? resp_q.pop_front() : 8'h00;
        end
    end

    always @(negedge spi_sck) spi_miso = s_cur[7];

    // transmit stream source
    bit tx_take = 1'b0;
    always @(negedge clk) begin
        if (tx_take) void'(tx_src.pop_front());
        tx_valid = (tx_src.size() > 0);
        tx_data  = tx_valid ? tx_src[0] : 8'h00;
        tx_take  = tx_valid && tx_ready;
    end

    // result monitor (scoreboard)
    task automatic pop_expect(input int kind, input int val, input string what);
        if (exp_q.size() == 0) begin
            check(1'b0, what, val, -1);
        end else begin
            automatic item_t it = exp_q.pop_front();
            check(it.kind == kind && it.val == val, it.req, val, it.val);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            rx_ready = ((bp % 3) != 2);
            bp++;
            if (rx_valid && rx_ready) pop_expect(1, int'(rx_data), "R6");
            if (rd_valid) pop_expect(0, int'(rd_data), "R4");
            if (done) begin
                pop_expect(2, int'(done_count), "R7");
                check(!busy && spi_cs_n, "R8", {busy, spi_cs_n}, 2'b01);
                n_done++;
            end
        end
    end

    task automatic push_mosi(input logic [7:0] b, input string r);
        mosi_exp.push_back(b);
        mosi_req.push_back(r);
    endtask

    task automatic push_exp(input int kind, input int val, input string r);
        automatic item_t it;
        it.kind = kind; it.val = val; it.req = r;
        exp_q.push_back(it);
    endtask

    task automatic issue(input logic [1:0] op, input logic [5:0] a, input logic [7:0] d,
                         input logic [7:0] l, input bit wait_done);
        automatic int prev = n_done;
        @(negedge clk);
        while (busy) @(negedge clk);
        cmd_op = op; cmd_addr = a; cmd_data = d; cmd_len = l; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(busy && !spi_cs_n, "R8", {busy, spi_cs_n}, 2'b10);
        if (wait_done) while (n_done == prev) @(negedge clk);
    endtask

    task automatic reg_write(input logic [5:0] a, input logic [7:0] d);
        push_mosi(8'hC0 | {2'b00, a}, "R3");
        push_mosi(d, "R3");
        push_exp(2, 0, "R7");
        issue(2'd0, a, d, 8'd0, 1'b1);
    endtask

    task automatic reg_read(input logic [5:0] a, input logic [7:0] v);
        push_mosi(8'h80 | {2'b00, a}, "R4");
        push_mosi(8'h00, "R4");
        resp_q.push_back(8'h5A);
        resp_q.push_back(v);
        push_exp(0, int'(v), "R4");
        push_exp(2, 0, "R7");
        issue(2'd1, a, 8'h00, 8'd0, 1'b1);
    endtask

    task automatic buf_write(input int n, input int seed);
        push_mosi(8'h60, "R5");
        push_mosi(8'(n), "R5");
        for (int i = 0; i < n; i++) begin
            tx_src.push_back(8'(i * 37 + seed));
            push_mosi(8'(i * 37 + seed), "R5");
        end
        push_exp(2, 0, "R7");
        issue(2'd2, 6'd0, 8'h00, 8'(n), 1'b1);
        check(tx_src.size() == 0, "R5", tx_src.size(), 0);
    endtask

    task automatic buf_read(input int flen, input int maxl, input int seed);
        automatic int got = (flen + 1 > maxl) ? maxl : flen + 1;
        push_mosi(8'h20, "R6");
        push_mosi(8'h00, "R6");
        resp_q.push_back(8'hEE);
        resp_q.push_back(8'(flen));
        for (int i = 0; i < got; i++) begin
            push_mosi(8'h00, "R6");
            resp_q.push_back(8'(i * 53 + seed));
            push_exp(1, (i * 53 + seed) & 8'hFF, "R6");
        end
        push_exp(2, got, "R7");
        issue(2'd3, 6'd0, 8'h00, 8'(maxl), 1'b1);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        check(spi_cs_n && !spi_sck && !busy && !done && !irq_flag, "R1",
              {spi_cs_n, spi_sck, busy, done, irq_flag}, 5'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        check(spi_cs_n && !spi_sck && !busy && !done, "R1",
              {spi_cs_n, spi_sck, busy, done}, 4'b1000);

        reg_write(6'h15, 8'hA5);
        reg_write(6'h3F, 8'h01);
        reg_read(6'h02, 8'h9C);
        reg_read(6'h3F, 8'h00);
        buf_write(4, 5);
        buf_write(0, 0);
        buf_read(3, 10, 7);
        buf_read(7, 5, 11);
        buf_read(0, 0, 0);
        buf_read(0, 8, 200);
        buf_read(255, 255, 1);

        // R8: a command while busy is ignored; R10: select high between transactions
        push_mosi(8'hC0 | 8'h01, "R3");
        push_mosi(8'h77, "R3");
        push_exp(2, 0, "R7");
        issue(2'd0, 6'h01, 8'h77, 8'd0, 1'b0);
        repeat (5) @(negedge clk);
        cmd_op = 2'd3; cmd_len = 8'd9; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy) @(negedge clk);
        repeat (60) @(negedge clk);
        check(spi_cs_n && !busy, "R8", {spi_cs_n, busy}, 2'b10);

        // back-to-back: select must rise for a cycle
        push_mosi(8'hC2, "R10");
        push_mosi(8'h11, "R10");
        push_exp(2, 0, "R7");
        issue(2'd0, 6'h02, 8'h11, 8'd0, 1'b0);
        cmd_op = 2'd0; cmd_addr = 6'h03; cmd_data = 8'h22; cmd_valid = 1'b1;
        push_mosi(8'hC3, "R10");
        push_mosi(8'h22, "R10");
        push_exp(2, 0, "R7");
        while (!done) @(negedge clk);
        check(spi_cs_n == 1'b1, "R10", spi_cs_n, 1);
        @(negedge clk);
        cmd_valid = 1'b0;
        check(!spi_cs_n && busy, "R10", spi_cs_n, 0);
        while (busy) @(negedge clk);

        // R9: interrupt level synchronisation
        irq_in = 1'b1;
        @(negedge clk);
        check(irq_flag == 1'b0, "R9", irq_flag, 0);
        @(negedge clk);
        check(irq_flag == 1'b1, "R9", irq_flag, 1);
        irq_in = 1'b0;
        @(negedge clk);
        check(irq_flag == 1'b1, "R9", irq_flag, 1);
        @(negedge clk);
        check(irq_flag == 1'b0, "R9", irq_flag, 0);

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R7", exp_q.size(), 0);
        check(mosi_exp.size() == 0, "R2", mosi_exp.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule